// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by requiring a service strobe at the right time rather than just often enough. Each supervision period has two phases. A closed phase comes first, and service is forbidden during it. An open phase follows, and the service must land there. A service that arrives during the closed phase is treated as a fault and raises the interrupt. It does not restart the period. A valid service during the open phase starts a fresh period at the beginning of the closed phase. If the open phase runs out with no valid service, the reset output is asserted.

Time is counted in prescaled ticks. A tick occurs once every P clock cycles, where P is the prescale field plus one. So a phase of L ticks lasts L·P clock cycles. A programmable lead value places a warning point that many ticks before the closed phase ends. At that point a sticky interrupt is raised so that software knows servicing will soon be due. The interrupt stays high until a clear strobe removes it. The reset output is a pulse of fixed length. When it ends, the block waits idle until the enable input has been released and raised again.

Top module: `win_watchdog`

## Requirements
- R1: Timing scales with the prescaler. With P = pre_div + 1, and with no service, wdt_rst rises (closed_len + open_len)·P clock edges after the edge that starts a period.
- R2: A service strobe sampled while the closed phase is active sets irq on the next edge. It does not restart the period, so the timeout edge stays the same.
- R3: A service strobe sampled while the open phase is active starts a new period at that edge. The warning and the timeout are then timed from that edge.
- R4: When warn_lead < closed_len, irq rises (closed_len − warn_lead)·P edges after the period start.
- R5: irq is sticky. Only an irq_clear strobe removes it, one edge later. If a warning or a fault is sampled on the same edge as the clear, irq stays set.
- R6: If the open phase ends with no valid service, wdt_rst goes high on that final tick edge.
- R7: wdt_rst stays high for exactly 16 cycles. The block then stays idle, and no warning or reset occurs, until enable falls and rises again.
- R8: A service is judged by the phase in force before the edge that samples it. On the closed-to-open tick edge, a service counts as a fault. On the final open tick edge, a service counts as valid and wins over the timeout.
- R9: Dropping enable during the closed or open phase stops the timer. No later warning or reset occurs.
- R10: The synchronous reset clears irq and wdt_rst and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | A rising level starts supervision; a low level stops it |
| service | input | 1 | Single-cycle service strobe |
| irq_clear | input | 1 | Single-cycle strobe that clears irq |
| pre_div | input | PRE_W | Prescale field; tick period P = pre_div + 1 |
| closed_len | input | CNT_W | Closed phase length in ticks (≥ 1) |
| open_len | input | CNT_W | Open phase length in ticks (≥ 1) |
| warn_lead | input | CNT_W | Ticks before the closed phase ends at which the warning fires |
| irq | output | 1 | Sticky interrupt: warning or early service |
| wdt_rst | output | 1 | Reset pulse after a missed open phase |

## Verification
The assertions rely on four conditions. The phase lengths are at least one tick, warn_lead is below closed_len, the configuration inputs do not change while a period is running, and service and irq_clear are single-cycle strobes. The stimulus changes pre_div and the three lengths only while the block is idle, either before enable rises or after a reset pulse has ended. It drives every strobe for exactly one cycle on a falling clock edge. Boundary strobes are placed on the exact tick edges where a phase changes, so that the rule of judging each strobe by the phase before that edge is exercised in both directions.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2,
    PH_HOLD   = 2'd3
  } wdt_phase_e;

  // True when the tick now being taken completes a phase of len ticks,
  // given that done ticks of it have already elapsed.
  function automatic logic ends_phase(input logic [31:0] done,
                                      input logic [31:0] len);
    return ({1'b0, done} + 33'd1) == {1'b0, len};
  endfunction

  // True when the tick now being taken leaves exactly lead ticks of the
  // closed phase remaining.
  function automatic logic hits_warn(input logic [31:0] done,
                                     input logic [31:0] len,
                                     input logic [31:0] lead);
    return ({2'b0, done} + 34'd1 + {2'b0, lead}) == {2'b0, len};
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_div,
  output logic             tick
);
  logic [PRE_W-1:0] pc;

  assign tick = run && (pc == pre_div);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) pc <= '0;
    else if (tick)              pc <= '0;
    else                        pc <= pc + 1'b1;
  end
endmodule

// File: rtl/wdt_hold_timer.sv
module wdt_hold_timer #(
  parameter int HOLD_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_hold,
  output logic hold_last
);
  localparam int HW = $clog2(HOLD_LEN + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_LEN - 1);

  logic [HW-1:0] hc;

  assign hold_last = in_hold && (hc == LAST);

  always_ff @(posedge clk) begin
    if (rst || !in_hold) hc <= '0;
    else                 hc <= hc + 1'b1;
  end
endmodule

// File: rtl/wdt_window_fsm.sv
module wdt_window_fsm
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             service,
  input  logic             tick,
  input  logic             hold_last,
  input  logic [CNT_W-1:0] closed_len,
  input  logic [CNT_W-1:0] open_len,
  input  logic [CNT_W-1:0] warn_lead,
  output wdt_phase_e       phase,
  output logic             run,
  output logic             warn_evt,
  output logic             early_evt,
  output logic             valid_svc,
  output logic             timeout_evt
);
  logic [CNT_W-1:0] done;
  logic             en_q;
  logic             closed_end;
  logic             open_end;

  assign closed_end = ends_phase(32'(done), 32'(closed_len));
  assign open_end   = ends_phase(32'(done), 32'(open_len));

  always_comb begin
    run         = enable && (phase == PH_CLOSED || phase == PH_OPEN);
    warn_evt    = enable && (phase == PH_CLOSED) && tick &&
                  hits_warn(32'(done), 32'(closed_len), 32'(warn_lead));
    early_evt   = enable && (phase == PH_CLOSED) && service;
    valid_svc   = enable && (phase == PH_OPEN) && service;
    timeout_evt = enable && (phase == PH_OPEN) && tick && open_end && !service;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      done  <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= enable;
      unique case (phase)
        PH_IDLE: begin
          done <= '0;
          if (enable && !en_q) phase <= PH_CLOSED;
        end
        PH_CLOSED: begin
          if (!enable) begin
            phase <= PH_IDLE;
            done  <= '0;
          end else if (tick) begin
            if (closed_end) begin
              phase <= PH_OPEN;
              done  <= '0;
            end else begin
              done <= done + 1'b1;
            end
          end
        end
        PH_OPEN: begin
          if (!enable) begin
            phase <= PH_IDLE;
            done  <= '0;
          end else if (valid_svc) begin
            phase <= PH_CLOSED;
            done  <= '0;
          end else if (tick) begin
            if (open_end) begin
              phase <= PH_HOLD;
              done  <= '0;
            end else begin
              done <= done + 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (hold_last) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int HOLD_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             service,
  input  logic             irq_clear,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [CNT_W-1:0] closed_len,
  input  logic [CNT_W-1:0] open_len,
  input  logic [CNT_W-1:0] warn_lead,
  output logic             irq,
  output logic             wdt_rst
);
  wdt_phase_e phase_w;
  logic run_w, tick_w, hold_last_w;
  logic warn_w, early_w, valid_w, timeout_w;

  wdt_prescaler #(.PRE_W(PRE_W)) presc_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .restart (valid_w),
    .pre_div (pre_div),
    .tick    (tick_w)
  );

  wdt_window_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .service     (service),
    .tick        (tick_w),
    .hold_last   (hold_last_w),
    .closed_len  (closed_len),
    .open_len    (open_len),
    .warn_lead   (warn_lead),
    .phase       (phase_w),
    .run         (run_w),
    .warn_evt    (warn_w),
    .early_evt   (early_w),
    .valid_svc   (valid_w),
    .timeout_evt (timeout_w)
  );

  wdt_hold_timer #(.HOLD_LEN(HOLD_LEN)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .in_hold   (phase_w == PH_HOLD),
    .hold_last (hold_last_w)
  );

  assign wdt_rst = (phase_w == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst)                   irq <= 1'b0;
    else if (warn_w || early_w) irq <= 1'b1;
    else if (irq_clear)        irq <= 1'b0;
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int HOLD_LEN = 16
) (
  input logic clk,
  input logic rst,
  input logic irq_clear,
  input logic irq,
  input logic wdt_rst,
  input logic warn_evt,
  input logic early_evt,
  input logic valid_svc,
  input logic timeout_evt
);
  int unsigned hi_run;

  always_ff @(posedge clk) begin
    if (rst)          hi_run <= 0;
    else if (wdt_rst) hi_run <= hi_run + 1;
    else              hi_run <= 0;
  end

  // R2 R4
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (warn_evt || early_evt) |=> irq);

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clear && !warn_evt && !early_evt) |=> !irq);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && !warn_evt && !early_evt) |=> !irq);

  // R6
  timeout_rst_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> wdt_rst);

  // R6
  rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!wdt_rst && !timeout_evt) |=> !wdt_rst);

  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst && hi_run < HOLD_LEN - 1) |=> wdt_rst);

  // R7
  rst_end_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst && hi_run == HOLD_LEN - 1) |=> !wdt_rst);

  // R3
  svc_no_rst_chk: assert property (@(posedge clk) disable iff (rst)
    valid_svc |=> !wdt_rst);

  // R8
  svc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    early_evt |-> !valid_svc);
endmodule

bind win_watchdog wdt_chk #(.HOLD_LEN(HOLD_LEN)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .irq_clear   (irq_clear),
  .irq         (irq),
  .wdt_rst     (wdt_rst),
  .warn_evt    (warn_w),
  .early_evt   (early_w),
  .valid_svc   (valid_w),
  .timeout_evt (timeout_w)
);

// File: tb/win_watchdog_tb_top.sv
`timescale 1ns/1ps
module win_watchdog_tb_top;
  localparam int CNT_W = 16;
  localparam int PRE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, service = 1'b0, irq_clear = 1'b0;
  logic [PRE_W-1:0] pre_div = '0;
  logic [CNT_W-1:0] closed_len = '0, open_len = '0, warn_lead = '0;
  logic irq, wdt_rst;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  win_watchdog #(.CNT_W(CNT_W), .PRE_W(PRE_W), .HOLD_LEN(16)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .service(service),
    .irq_clear(irq_clear), .pre_div(pre_div), .closed_len(closed_len),
    .open_len(open_len), .warn_lead(warn_lead), .irq(irq), .wdt_rst(wdt_rst)
  );

  typedef struct {
    int    at;
    bit    is_rst;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic expect_at(int at, bit is_rst, bit val, string tag);
    exp_t e;
    e.at = at; e.is_rst = is_rst; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pops every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic got;
        got = sb[i].is_rst ? wdt_rst : irq;
        checks++;
        if (got !== sb[i].val) begin
          errors++;
          $display("FAIL %s: %s actual=%0b expected=%0b cycle=%0d", sb[i].tag,
                   sb[i].is_rst ? "wdt_rst" : "irq", got, sb[i].val, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic wait_neg(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse_svc(int n);
    wait_neg(n); service = 1'b1;
    @(negedge clk); service = 1'b0;
  endtask

  task automatic pulse_clr(int n);
    wait_neg(n); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  task automatic settle();
    enable = 1'b0;
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(int p, int c, int o, int w);
    pre_div = PRE_W'(p); closed_len = CNT_W'(c);
    open_len = CNT_W'(o); warn_lead = CNT_W'(w);
  endtask

  task automatic report();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      report();
    end
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    expect_at(cyc + 1, 0, 0, "R10 irq after reset");
    expect_at(cyc + 1, 1, 0, "R10 wdt_rst after reset");
    repeat (3) @(negedge clk);

    // A: plain timeout, P=2 C=4 O=3 W=1
    cfg(1, 4, 3, 1);
    t0 = cyc + 3;
    expect_at(t0 + 5, 0, 0, "R4 before warning");
    expect_at(t0 + 6, 0, 1, "R4 warning");
    expect_at(t0 + 12, 0, 1, "R5 irq sticky");
    expect_at(t0 + 13, 1, 0, "R1 before timeout");
    expect_at(t0 + 14, 1, 1, "R6 timeout");
    expect_at(t0 + 16, 0, 0, "R5 cleared");
    expect_at(t0 + 29, 1, 1, "R7 last hold cycle");
    expect_at(t0 + 30, 1, 0, "R7 hold ended");
    expect_at(t0 + 60, 0, 0, "R7 no restart irq");
    expect_at(t0 + 60, 1, 0, "R7 no restart rst");
    wait_neg(t0 - 1); enable = 1'b1;
    pulse_clr(t0 + 15);
    wait_neg(t0 + 61);
    settle();

    // B: valid service in the open phase
    t0 = cyc + 3;
    expect_at(t0 + 6, 0, 1, "R4 warning");
    expect_at(t0 + 8, 0, 0, "R5 cleared");
    expect_at(t0 + 14, 1, 0, "R3 no timeout after service");
    expect_at(t0 + 15, 0, 0, "R3 warning moved");
    expect_at(t0 + 16, 0, 1, "R3 warning after restart");
    expect_at(t0 + 23, 1, 0, "R3 before new timeout");
    expect_at(t0 + 24, 1, 1, "R3 new timeout");
    wait_neg(t0 - 1); enable = 1'b1;
    pulse_clr(t0 + 7);
    pulse_svc(t0 + 9);
    wait_neg(t0 + 42);
    settle();

    // C: early service is a fault, no reload
    t0 = cyc + 3;
    expect_at(t0 + 2, 0, 0, "R2 before early service");
    expect_at(t0 + 3, 0, 1, "R2 early fault irq");
    expect_at(t0 + 13, 1, 0, "R2 before timeout");
    expect_at(t0 + 14, 1, 1, "R2 timeout unchanged");
    wait_neg(t0 - 1); enable = 1'b1;
    pulse_svc(t0 + 2);
    wait_neg(t0 + 32);
    settle();

    // D: service on the closed-to-open edge
    t0 = cyc + 3;
    expect_at(t0 + 6, 0, 1, "R4 warning");
    expect_at(t0 + 7, 0, 0, "R5 cleared");
    expect_at(t0 + 8, 0, 1, "R8 boundary service is fault");
    expect_at(t0 + 14, 1, 1, "R8 boundary service no reload");
    wait_neg(t0 - 1); enable = 1'b1;
    pulse_clr(t0 + 6);
    pulse_svc(t0 + 7);
    wait_neg(t0 + 32);
    settle();

    // E: service on the final open tick edge
    t0 = cyc + 3;
    expect_at(t0 + 14, 1, 0, "R8 last-tick service wins");
    expect_at(t0 + 27, 1, 0, "R8 before later timeout");
    expect_at(t0 + 28, 1, 1, "R8 later timeout");
    wait_neg(t0 - 1); enable = 1'b1;
    pulse_svc(t0 + 13);
    wait_neg(t0 + 46);
    settle();

    // F: P=1 C=3 O=2 W=0, clear on the warning edge
    cfg(0, 3, 2, 0);
    t0 = cyc + 3;
    expect_at(t0 + 2, 0, 0, "R4 before warning");
    expect_at(t0 + 3, 0, 1, "R5 set beats clear");
    expect_at(t0 + 4, 1, 0, "R1 before timeout");
    expect_at(t0 + 5, 1, 1, "R1 timeout with P=1");
    wait_neg(t0 - 1); enable = 1'b1;
    pulse_clr(t0 + 2);
    wait_neg(t0 + 24);
    settle();

    // G: enable dropped mid-period
    cfg(1, 4, 3, 1);
    t0 = cyc + 3;
    expect_at(t0 + 10, 0, 0, "R9 no warning");
    expect_at(t0 + 16, 1, 0, "R9 no timeout");
    expect_at(t0 + 30, 0, 0, "R9 still quiet");
    expect_at(t0 + 30, 1, 0, "R9 still no reset");
    wait_neg(t0 - 1); enable = 1'b1;
    wait_neg(t0 + 3); enable = 1'b0;
    wait_neg(t0 + 31);
    settle();

    // H: synchronous reset mid-period
    t0 = cyc + 3;
    expect_at(t0 + 3, 0, 1, "R2 early fault irq");
    expect_at(t0 + 5, 0, 0, "R10 reset clears irq");
    expect_at(t0 + 14, 1, 0, "R10 no timeout after reset");
    expect_at(t0 + 20, 0, 0, "R10 idle after reset");
    wait_neg(t0 - 1); enable = 1'b1;
    pulse_svc(t0 + 2);
    wait_neg(t0 + 4); rst = 1'b1; enable = 1'b0;
    @(negedge clk); rst = 1'b0;
    wait_neg(t0 + 22);

    foreach (sb[i]) begin
      checks++; errors++;
      $display("FAIL %s: unchecked actual=none expected=%0b", sb[i].tag, sb[i].val);
    end
    report();
  end
endmodule